// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other over up to sixteen channels. Each channel holds one "occupied" flag per processor. A processor sets its own flag for a channel to announce a message. The other processor sees that flag, handles the message, and then clears it, which tells the sender that the channel is free again. No payload travels through the block; it carries only the flags and the interrupts derived from them.

Each processor has its own register port and its own bank of four registers:

| Register | Offset | Access | Contents |
|----------|--------|--------|----------|
| control | 0x000 | read/write | interrupt enables |
| mask | 0x004 | read/write | per-channel interrupt masks |
| set/clear | 0x008 | write-only | flag commands |
| status | 0x00C | read-only | the processor's own flags |

Processor 1's bank starts 0x10 above processor 0's. Two read-only words are shared by both processors:

| Register | Offset | Contents |
|----------|--------|----------|
| channel count | 0x3F0 | number of implemented channels |
| revision | 0x3F4 | revision number |

Each processor gets two level interrupts. Its receive interrupt asks for attention when the peer has occupied a channel. Its transmit interrupt reports that one of its own channels has become free.

The register ports are plain single-cycle strobes. A write takes effect at the clock edge that samples it. Because the ports carry register accesses and not a data stream, they have no ready signal and never apply back-pressure.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset, all status flags are 0, both control registers read 0, each mask register reads 1 in every bit of an implemented channel in both halves, and all four interrupt outputs are 0.
- R2: A write to a processor's set/clear register (bank offset 0x008) with bit 16+n at 1 sets channel n in that processor's own status register (bank offset 0x00C, bit n).
- R3: In the same write, bit n at 1 clears channel n in the peer processor's status. Bits written as 0 change nothing, and with no set/clear write all flags hold.
- R4: When a set of a flag and a clear of the same flag land in the same cycle, the flag ends up set.
- R5: The receive interrupt `rx_irq[p]` is registered. It equals the previous cycle's value of: control bit 0 of processor p AND (any channel occupied in the peer's status AND unmasked in bits 15:0 of p's mask).
- R6: The transmit interrupt `tx_irq[p]` is registered. It equals the previous cycle's value of: control bit 16 of processor p AND (any channel not occupied in p's own status AND unmasked in bits 31:16 of p's mask).
- R7: The control register stores only bit 0 (receive enable) and bit 16 (transmit enable); every other bit reads 0.
- R8: Channels at or above the parameter NCH (1 to 16) have status bits and mask bits that always read 0, and writes to them have no effect.
- R9: Offset 0x3F0 reads NCH in bits 7:0, and offset 0x3F4 reads the major revision in bits 7:4 and the minor revision in bits 3:0. Writes to either offset change nothing.
- R10: Port p reaches only its own bank, which starts at p*0x10. Writes to the other bank's offsets are ignored. Reads there return 0, and so does a read of the set/clear register.
- R11: `p_rdata[p]` is loaded at the clock edge that samples `p_rd[p]` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| p_wr | input | 2 | write strobe, one per processor port |
| p_rd | input | 2 | read strobe, one per processor port |
| p_addr | input | 2x10 | byte address, one per processor port |
| p_wdata | input | 2x32 | write data, one per processor port |
| p_rdata | output | 2x32 | registered read data, one per processor port |
| rx_irq | output | 2 | receive interrupt, one per processor |
| tx_irq | output | 2 | transmit-free interrupt, one per processor |

## Verification
Two functions can land in the same cycle on one flag:
- a sender setting its own occupied flag;
- the receiver clearing that flag through its clear half.

The bench provokes this in two ways:
- a directed test has both ports hit the same channel at the same edge;
- a random phase drives both ports every cycle, with write data biased toward the low channels so that the set and clear halves overlap often.

Each collision is judged in two places. A bench model applies the rule that a set wins, and the bench compares the model with the status read back and with the interrupt outputs two edges later. A bound property checks that every bit a port sets is present in the following cycle, whatever the peer did.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 32;
  localparam int unsigned HALF = 16;

  localparam logic [AW-1:0] OFS_CTRL   = 10'h000;
  localparam logic [AW-1:0] OFS_MASK   = 10'h004;
  localparam logic [AW-1:0] OFS_SETCLR = 10'h008;
  localparam logic [AW-1:0] OFS_STAT   = 10'h00C;
  localparam logic [AW-1:0] BANK_STEP  = 10'h010;
  localparam logic [AW-1:0] OFS_COUNT  = 10'h3F0;
  localparam logic [AW-1:0] OFS_REV    = 10'h3F4;

  localparam int unsigned RX_EN_BIT = 0;
  localparam int unsigned TX_EN_BIT = 16;

  // Write strobes that one port's decoder hands to its own bank.
  typedef struct packed {
    logic          ctrl_we;
    logic          mask_we;
    logic          sc_we;
    logic [DW-1:0] wdata;
  } bank_wr_t;

  // One bit for each implemented channel.
  function automatic logic [HALF-1:0] chan_mask(input int unsigned n);
    logic [HALF-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < HALF; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter int unsigned PID     = 0,
  parameter int unsigned NCH     = 16,
  parameter int unsigned VER_MAJ = 1,
  parameter int unsigned VER_MIN = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   ctrl_rd,
  input  logic [DW-1:0]   mask_rd,
  input  logic [HALF-1:0] stat_rd,
  output bank_wr_t        bwr,
  output logic [DW-1:0]   rdata
);
  localparam logic [AW-1:0] BASE      = (PID == 0) ? 10'h000 : BANK_STEP;
  localparam logic [AW-1:0] A_CTRL    = BASE + OFS_CTRL;
  localparam logic [AW-1:0] A_MASK    = BASE + OFS_MASK;
  localparam logic [AW-1:0] A_SETCLR  = BASE + OFS_SETCLR;
  localparam logic [AW-1:0] A_STAT    = BASE + OFS_STAT;
  localparam logic [7:0]    COUNT_VAL = 8'(NCH);
  localparam logic [7:0]    REV_VAL   = {4'(VER_MAJ), 4'(VER_MIN)};

  logic [DW-1:0] rsel;

  // Write decode: only this port's own bank is reachable.
  always_comb begin
    bwr         = '0;
    bwr.wdata   = wdata;
    bwr.ctrl_we = wr && (addr == A_CTRL);
    bwr.mask_we = wr && (addr == A_MASK);
    bwr.sc_we   = wr && (addr == A_SETCLR);
  end

  // Read select. The set/clear offset and every unmapped offset read 0.
  always_comb begin
    rsel = '0;
    if (addr == A_CTRL) begin
      rsel = ctrl_rd;
    end else if (addr == A_MASK) begin
      rsel = mask_rd;
    end else if (addr == A_STAT) begin
      rsel = {{(DW-HALF){1'b0}}, stat_rd};
    end else if (addr == OFS_COUNT) begin
      rsel = {{(DW-8){1'b0}}, COUNT_VAL};
    end else if (addr == OFS_REV) begin
      rsel = {{(DW-8){1'b0}}, REV_VAL};
    end
  end

  // Read data is loaded on a read strobe and held otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rsel;
    end
  end
endmodule

// File: rtl/mbox_ctrl_regs.sv
module mbox_ctrl_regs
  import mbox_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bank_wr_t      bwr,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] mask_q
);
  localparam logic [HALF-1:0] CHM       = chan_mask(NCH);
  localparam logic [DW-1:0]   MASK_KEEP = {CHM, CHM};
  localparam logic [DW-1:0]   CTRL_KEEP = (DW'(1) << RX_EN_BIT) | (DW'(1) << TX_EN_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= MASK_KEEP;
    end else begin
      if (bwr.ctrl_we) ctrl_q <= bwr.wdata & CTRL_KEEP;
      if (bwr.mask_we) mask_q <= bwr.wdata & MASK_KEEP;
    end
  end
endmodule

// File: rtl/mbox_flag_array.sv
module mbox_flag_array
  import mbox_pkg::*;
#(
  parameter int unsigned NPROC = 2,
  parameter int unsigned NCH   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPROC-1:0][HALF-1:0] set_req,
  input  logic [NPROC-1:0][HALF-1:0] clr_req,
  output logic [NPROC-1:0][HALF-1:0] stat_q
);
  localparam logic [HALF-1:0] CHM = chan_mask(NCH);

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    // A set beats a clear of the same flag in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[p] <= '0;
      end else begin
        stat_q[p] <= ((stat_q[p] & ~clr_req[p]) | set_req[p]) & CHM;
      end
    end
  end
endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen
  import mbox_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          rx_en,
  input  logic [1:0]          tx_en,
  input  logic [1:0][DW-1:0]  mask,
  input  logic [1:0][HALF-1:0] stat,
  output logic [1:0]          rx_irq,
  output logic [1:0]          tx_irq
);
  localparam logic [HALF-1:0] CHM = chan_mask(NCH);

  for (genvar p = 0; p < 2; p++) begin : g_irq
    localparam int unsigned Q = 1 - p;
    logic rx_hit;
    logic tx_hit;

    // Receive: the peer has occupied a channel that this side has unmasked.
    assign rx_hit = |(stat[Q] & ~mask[p][HALF-1:0] & CHM);
    // Transmit: an own channel is free and this side has unmasked it.
    assign tx_hit = |(~stat[p] & ~mask[p][DW-1:HALF] & CHM);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_irq[p] <= 1'b0;
        tx_irq[p] <= 1'b0;
      end else begin
        rx_irq[p] <= rx_en[p] & rx_hit;
        tx_irq[p] <= tx_en[p] & tx_hit;
      end
    end
  end
endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned NCH     = 12,
  parameter int unsigned VER_MAJ = 1,
  parameter int unsigned VER_MIN = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          p_wr,
  input  logic [1:0]          p_rd,
  input  logic [1:0][AW-1:0]  p_addr,
  input  logic [1:0][DW-1:0]  p_wdata,
  output logic [1:0][DW-1:0]  p_rdata,
  output logic [1:0]          rx_irq,
  output logic [1:0]          tx_irq
);
  bank_wr_t [1:0]        bwr;
  logic [1:0][DW-1:0]    ctrl_v;
  logic [1:0][DW-1:0]    mask_v;
  logic [1:0][HALF-1:0]  own_stat;
  logic [1:0][HALF-1:0]  set_req;
  logic [1:0][HALF-1:0]  clr_req;
  logic [1:0]            rx_en;
  logic [1:0]            tx_en;

  for (genvar p = 0; p < 2; p++) begin : g_bank
    localparam int unsigned Q = 1 - p;

    mbox_port_dec #(
      .PID(p), .NCH(NCH), .VER_MAJ(VER_MAJ), .VER_MIN(VER_MIN)
    ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (p_wr[p]),
      .rd      (p_rd[p]),
      .addr    (p_addr[p]),
      .wdata   (p_wdata[p]),
      .ctrl_rd (ctrl_v[p]),
      .mask_rd (mask_v[p]),
      .stat_rd (own_stat[p]),
      .bwr     (bwr[p]),
      .rdata   (p_rdata[p])
    );

    mbox_ctrl_regs #(.NCH(NCH)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .bwr    (bwr[p]),
      .ctrl_q (ctrl_v[p]),
      .mask_q (mask_v[p])
    );

    // A processor's upper half sets its own flags; the peer's lower half clears them.
    assign set_req[p] = bwr[p].sc_we ? bwr[p].wdata[DW-1:HALF] : '0;
    assign clr_req[p] = bwr[Q].sc_we ? bwr[Q].wdata[HALF-1:0]  : '0;
    assign rx_en[p]   = ctrl_v[p][RX_EN_BIT];
    assign tx_en[p]   = ctrl_v[p][TX_EN_BIT];
  end

  mbox_flag_array #(.NPROC(2), .NCH(NCH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .clr_req (clr_req),
    .stat_q  (own_stat)
  );

  mbox_irq_gen #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_en  (rx_en),
    .tx_en  (tx_en),
    .mask   (mask_v),
    .stat   (own_stat),
    .rx_irq (rx_irq),
    .tx_irq (tx_irq)
  );
endmodule

// File: rtl/mbox_flag_ctrl_chk.sv
module mbox_flag_ctrl_chk
  import mbox_pkg::*;
#(
  parameter int unsigned NCH = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          p_wr,
  input logic [1:0][AW-1:0]  p_addr,
  input logic [1:0][DW-1:0]  p_wdata,
  input logic [1:0][HALF-1:0] stat,
  input logic [1:0][DW-1:0]  ctrl,
  input logic [1:0][DW-1:0]  mask,
  input logic [1:0]          rx_irq,
  input logic [1:0]          tx_irq
);
  localparam logic [HALF-1:0] CHM = chan_mask(NCH);

  logic sc0;
  logic sc1;
  assign sc0 = p_wr[0] && (p_addr[0] == OFS_SETCLR);
  assign sc1 = p_wr[1] && (p_addr[1] == BANK_STEP + OFS_SETCLR);

  // Bits a port sets are present in the next cycle, even under a peer clear.
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc0 |=> ((stat[0] & $past(p_wdata[0][DW-1:HALF] & CHM)) == $past(p_wdata[0][DW-1:HALF] & CHM)));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sc1 |=> ((stat[1] & $past(p_wdata[1][DW-1:HALF] & CHM)) == $past(p_wdata[1][DW-1:HALF] & CHM)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc1 && !sc0) |=> ((stat[0] & $past(p_wdata[1][HALF-1:0])) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc0 && !sc1) |=> $stable(stat));

  p_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat[0] | stat[1]) & ~CHM) == '0) && (((mask[0] | mask[1]) & ~{CHM, CHM}) == '0));

  p_rx0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_irq[0] == $past(ctrl[0][RX_EN_BIT] && (|(stat[1] & ~mask[0][HALF-1:0])))));

  p_rx1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_irq[1] == $past(ctrl[1][RX_EN_BIT] && (|(stat[0] & ~mask[1][HALF-1:0])))));

  p_tx0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_irq[0] == $past(ctrl[0][TX_EN_BIT] && (|(~stat[0] & ~mask[0][DW-1:HALF] & CHM)))));

  p_tx1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_irq[1] == $past(ctrl[1][TX_EN_BIT] && (|(~stat[1] & ~mask[1][DW-1:HALF] & CHM)))));
endmodule

bind mbox_flag_ctrl mbox_flag_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .p_wr    (p_wr),
  .p_addr  (p_addr),
  .p_wdata (p_wdata),
  .stat    (own_stat),
  .ctrl    (ctrl_v),
  .mask    (mask_v),
  .rx_irq  (rx_irq),
  .tx_irq  (tx_irq)
);

// File: tb/mbox_flag_ctrl_bench.sv
`timescale 1ns/1ps
module mbox_flag_ctrl_bench;
  localparam int unsigned NCH = 12;
  localparam logic [15:0] CHM = 16'h0FFF;
  localparam logic [9:0] O_CTRL = 10'h000, O_MASK = 10'h004, O_SC = 10'h008, O_STAT = 10'h00C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] p_wr = '0;
  logic [1:0] p_rd = '0;
  logic [1:0][9:0] p_addr = '0;
  logic [1:0][31:0] p_wdata = '0;
  logic [1:0][31:0] p_rdata;
  logic [1:0] rx_irq;
  logic [1:0] tx_irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [15:0] mstat [2];
  logic [31:0] mctrl [2];
  logic [31:0] mmask [2];

  always #5 clk = ~clk;

  mbox_flag_ctrl #(.NCH(NCH), .VER_MAJ(1), .VER_MIN(0)) u_mbox_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .p_wr(p_wr), .p_rd(p_rd), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_rdata(p_rdata), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  function automatic logic [9:0] bank(input int p, input logic [9:0] ofs);
    return (p == 0) ? ofs : 10'h010 + ofs;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int p = 0; p < 2; p++) begin
      v[p]     = mctrl[p][0]  && (|(mstat[1-p] & ~mmask[p][15:0] & CHM));
      v[2 + p] = mctrl[p][16] && (|(~mstat[p] & ~mmask[p][31:16] & CHM));
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_apply(input logic w0, input logic [9:0] a0, input logic [31:0] d0,
                             input logic w1, input logic [9:0] a1, input logic [31:0] d1);
    logic [1:0] w;
    logic [9:0] a [2];
    logic [31:0] d [2];
    logic [1:0] sc;
    w = {w1, w0}; a[0] = a0; a[1] = a1; d[0] = d0; d[1] = d1;
    for (int p = 0; p < 2; p++) sc[p] = w[p] && (a[p] == bank(p, O_SC));
    for (int p = 0; p < 2; p++) begin
      logic [15:0] setv;
      logic [15:0] clrv;
      setv = sc[p] ? d[p][31:16] : 16'h0;
      clrv = sc[1-p] ? d[1-p][15:0] : 16'h0;
      mstat[p] = ((mstat[p] & ~clrv) | setv) & CHM;
      if (w[p] && a[p] == bank(p, O_CTRL)) mctrl[p] = d[p] & 32'h0001_0001;
      if (w[p] && a[p] == bank(p, O_MASK)) mmask[p] = d[p] & {CHM, CHM};
    end
  endtask

  task automatic put(input logic w0, input logic [9:0] a0, input logic [31:0] d0,
                     input logic w1, input logic [9:0] a1, input logic [31:0] d1);
    p_wr = {w1, w0}; p_rd = '0;
    p_addr[0] = a0; p_wdata[0] = d0; p_addr[1] = a1; p_wdata[1] = d1;
    model_apply(w0, a0, d0, w1, a1, d1);
  endtask

  task automatic wr1(input int p, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    if (p == 0) put(1'b1, a, d, 1'b0, 10'h0, 32'h0);
    else        put(1'b0, 10'h0, 32'h0, 1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      p_wr = '0; p_rd = '0;
    end
  endtask

  task automatic rd(input int p, input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    p_wr = '0; p_rd = '0; p_rd[p] = 1'b1; p_addr[p] = a;
    @(negedge clk);
    p_rd = '0;
    v = p_rdata[p];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    logic [3:0] exp_d1;
    logic [3:0] exp_d2;
    void'($urandom(32'd20240611));
    for (int p = 0; p < 2; p++) begin
      mstat[p] = '0; mctrl[p] = '0; mmask[p] = {CHM, CHM};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irqs", {28'h0, tx_irq, rx_irq}, 32'h0);
    rd(0, O_CTRL, v);            check("R1 ctrl0", v, 32'h0);
    rd(1, bank(1, O_MASK), v);   check("R1 mask1", v, 32'h0FFF_0FFF);
    rd(0, O_STAT, v);            check("R1 stat0", v, 32'h0);
    rd(1, bank(1, O_STAT), v);   check("R1 stat1", v, 32'h0);

    // R9 shared words, read-only
    rd(1, 10'h3F0, v);           check("R9 count", v, 32'd12);
    rd(0, 10'h3F4, v);           check("R9 rev", v, 32'h10);
    wr1(0, 10'h3F0, 32'hFF);
    rd(0, 10'h3F0, v);           check("R9 count after write", v, 32'd12);

    // R7 control keeps only the two enable bits
    wr1(0, O_CTRL, 32'hFFFF_FFFF);
    rd(0, O_CTRL, v);            check("R7 ctrl", v, 32'h0001_0001);
    wr1(0, O_CTRL, 32'h0);
    // R8 mask bits above the channel count stay 0
    wr1(0, O_MASK, 32'hFFFF_FFFF);
    rd(0, O_MASK, v);            check("R8 mask", v, 32'h0FFF_0FFF);

    // R2 set own flags; R8 channel 15 is not implemented
    wr1(0, O_SC, 32'h8005_0000);
    rd(0, O_STAT, v);            check("R2 set stat0", v, 32'h5);
    // R3 zero bits do nothing
    wr1(0, O_SC, 32'h0);
    rd(0, O_STAT, v);            check("R3 zero write", v, 32'h5);

    // R5 receive interrupt for processor 1
    wr1(1, bank(1, O_CTRL), 32'h1);
    wr1(1, bank(1, O_MASK), 32'hFFFF_FFFE);
    idle(2);
    check("R5 rx1 raised", {30'h0, rx_irq}, 32'h2);
    wr1(1, bank(1, O_SC), 32'h1);
    idle(2);
    check("R5 rx1 cleared", {30'h0, rx_irq}, 32'h0);
    rd(0, O_STAT, v);            check("R3 peer clear", v, 32'h4);

    // R6 transmit interrupt for processor 0
    wr1(0, O_CTRL, 32'h0001_0000);
    wr1(0, O_MASK, 32'hFFFB_FFFF);
    idle(2);
    check("R6 tx0 busy", {30'h0, tx_irq}, 32'h0);
    wr1(1, bank(1, O_SC), 32'h4);
    idle(2);
    check("R6 tx0 free", {30'h0, tx_irq}, 32'h1);

    // R4 same-cycle set and clear of one flag: set wins
    @(negedge clk);
    put(1'b1, O_SC, 32'h0008_0000, 1'b1, bank(1, O_SC), 32'h0000_0008);
    rd(0, O_STAT, v);            check("R4 set wins", v, 32'h8);
    wr1(1, bank(1, O_SC), 32'h8);
    rd(0, O_STAT, v);            check("R4 later clear", v, 32'h0);

    // R10 bank windows
    wr1(0, bank(1, O_CTRL), 32'h0001_0000);
    rd(1, bank(1, O_CTRL), v);   check("R10 foreign write", v, 32'h1);
    rd(0, bank(1, O_STAT), v);   check("R10 foreign read", v, 32'h0);
    rd(0, O_SC, v);              check("R10 setclr reads 0", v, 32'h0);

    // R11 read data holds without a read strobe
    rd(1, bank(1, O_STAT), held);
    wr1(1, bank(1, O_SC), 32'h0002_0000);
    idle(3);
    check("R11 rdata held", p_rdata[1], held);
    rd(1, bank(1, O_STAT), v);   check("R2 set stat1", v, 32'h2);

    // Random phase: both ports driven every cycle, irqs checked two edges later
    idle(3);
    exp_d1 = exp_irq();
    exp_d2 = exp_d1;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] w;
      logic [9:0] a [2];
      logic [31:0] d [2];
      @(negedge clk);
      check("R5 R6 random irqs", {28'h0, tx_irq, rx_irq}, {28'h0, exp_d2});
      exp_d2 = exp_d1;
      for (int p = 0; p < 2; p++) begin
        int unsigned r;
        r = $urandom % 8;
        w[p] = 1'b1;
        if (r < 3) begin
          a[p] = bank(p, O_SC);
          d[p] = ($urandom % 2 == 0) ? ($urandom & 32'h000F_000F) : ($urandom & $urandom);
        end else if (r == 3) begin
          a[p] = bank(p, O_MASK); d[p] = $urandom;
        end else if (r == 4) begin
          a[p] = bank(p, O_CTRL); d[p] = $urandom;
        end else if (r == 5) begin
          a[p] = bank(1 - p, O_SC); d[p] = $urandom;
        end else begin
          w[p] = 1'b0; a[p] = 10'h0; d[p] = 32'h0;
        end
      end
      put(w[0], a[0], d[0], w[1], a[1], d[1]);
      exp_d1 = exp_irq();
    end
    idle(1);

    // Final readback against the model
    for (int p = 0; p < 2; p++) begin
      rd(p, bank(p, O_STAT), v); check("R2 R3 final stat", v, {16'h0, mstat[p]});
      rd(p, bank(p, O_CTRL), v); check("R7 final ctrl", v, mctrl[p]);
      rd(p, bank(p, O_MASK), v); check("R8 final mask", v, mmask[p]);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule